// File: doc/BRIEF.md
# Rewindable FIFO with Half-Full Flag

A single-clock first-in/first-out buffer, 9 bits wide by default, whose depth is a parameter (256, 512 or 1024 words). Circular read and write pointers do the addressing, so the user only gives active-low write and read strobes. These strobes are sampled on the rising clock edge as synchronous enables. Status comes back on three active-low flags: empty, full and a hysteretic half-full. Read data is registered. An output-enable bit stands in for a three-state bus and is high only in the cycle that carries a word that was just read.

A rewind input, also active low, moves the read pointer back to location zero and leaves the write pointer where it is. The words written since reset can then be read out again from the first one. The flags follow the new distance between the pointers. Rewind is meant for runs of fewer than DEPTH writes between resets.

Top module: `fifo_rt`

## Requirements
- R1: While `rst_n` is low, and after it is released, the state is: occupancy zero, `empty_n` low, `full_n` high, `half_n` high, `dout_oe` low and `dout` zero.
- R2: A low `wr_n` while `full_n` is high stores `din`. Reads return the stored words in the order they were written.
- R3: `full_n` is low exactly when DEPTH words are held. With no reads after reset, that happens after DEPTH writes. While full, a write strobe is ignored and nothing is stored.
- R4: `empty_n` is low exactly when no words are held. While empty, a read strobe is ignored: `dout_oe` stays low and no word is consumed.
- R5: When both strobes are low on a buffer that is neither empty nor full, both are accepted and the occupancy is unchanged. When full, only the read is taken. When empty, only the write is taken.
- R6: `half_n` is low exactly when the occupancy exceeds DEPTH/2. It falls on the write that crosses that level and rises on the read that returns to DEPTH/2 or below.
- R7: A low `rt_n` sets the read pointer to location zero and leaves the write pointer unchanged. The flags then follow the occupancy, which equals the number of writes since reset. Strobes given while `rt_n` is low are ignored.
- R8: An accepted read puts the word on `dout` with `dout_oe` high in the next cycle. In every other cycle `dout_oe` is low and `dout` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_n | input | 1 | Write strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| rt_n | input | 1 | Rewind read pointer, active low |
| din | input | WIDTH | Write data |
| dout | output | WIDTH | Registered read data |
| dout_oe | output | 1 | High when `dout` carries a read word |
| empty_n | output | 1 | Empty flag, active low |
| full_n | output | 1 | Full flag, active low |
| half_n | output | 1 | More-than-half-full flag, active low |

## Verification
Short bursts of writes followed by reads show that ordering is kept and that the registered output timing is right. A complete fill, with extra writes pushed in, and then a complete drain separates full from empty. That run also checks the half-full threshold in both directions. Simultaneous strobes on a partly filled buffer, with the half-full level as the boundary, separate "both accepted" from "one dropped". A rewind after a partial read-out, including a rewind issued with strobes held low, shows that the write pointer is kept and that the words since reset are replayed.

// File: rtl/fifo_rt.sv
module fifo_rt #(
  parameter int DEPTH = 256,
  parameter int WIDTH = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_n,
  input  logic             rd_n,
  input  logic             rt_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout,
  output logic             dout_oe,
  output logic             empty_n,
  output logic             full_n,
  output logic             half_n
);
  // DEPTH is a power of two, so the pointers wrap naturally
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [CW-1:0] HALF_CNT = CW'(DEPTH / 2);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wptr, rptr;
  logic [CW-1:0]    count, count_nx;

  wire do_rt = !rt_n;
  wire do_wr = rt_n && !wr_n && full_n;
  wire do_rd = rt_n && !rd_n && empty_n;

  assign empty_n = (count != '0);
  assign full_n  = (count != FULL_CNT);

  always_comb begin
    if (do_rt)               count_nx = {1'b0, wptr};
    else if (do_wr && !do_rd) count_nx = count + 1'b1;
    else if (do_rd && !do_wr) count_nx = count - 1'b1;
    else                      count_nx = count;
  end

  always_ff @(posedge clk) begin
    if (do_wr) mem[wptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr    <= '0;
      rptr    <= '0;
      count   <= '0;
      half_n  <= 1'b1;
      dout    <= '0;
      dout_oe <= 1'b0;
    end else begin
      if (do_wr) wptr <= wptr + 1'b1;
      if (do_rt)      rptr <= '0;
      else if (do_rd) rptr <= rptr + 1'b1;
      count   <= count_nx;
      half_n  <= !(count_nx > HALF_CNT);
      dout_oe <= do_rd;
      dout    <= do_rd ? mem[rptr] : '0;
    end
  end
endmodule

// File: rtl/fifo_rt_chk.sv
module fifo_rt_chk #(
  parameter int DEPTH = 256,
  parameter int WIDTH = 9
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       wr_n,
  input logic                       rd_n,
  input logic                       rt_n,
  input logic [WIDTH-1:0]           dout,
  input logic                       dout_oe,
  input logic                       empty_n,
  input logic                       full_n,
  input logic                       half_n,
  input logic [$clog2(DEPTH)-1:0]   wptr,
  input logic [$clog2(DEPTH)-1:0]   rptr,
  input logic [$clog2(DEPTH):0]     count
);
  localparam int CW = $clog2(DEPTH) + 1;
  localparam logic [CW-1:0] HALF_CNT = CW'(DEPTH / 2);

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!full_n && !wr_n && rd_n) |=> $stable(wptr) && !full_n);

  assert_flags_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
    full_n || empty_n);

  assert_no_underflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!empty_n && !rd_n && rt_n) |=> !dout_oe && $stable(rptr));

  assert_both_strobes_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (empty_n && full_n && !wr_n && !rd_n && rt_n) |=> $stable(count));

  assert_half_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
    half_n == !(count > HALF_CNT));

  assert_rewind_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !rt_n |=> (rptr == '0) && $stable(wptr));

  assert_read_oe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (empty_n && !rd_n && rt_n) |=> dout_oe);

  assert_idle_bus_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !dout_oe |-> (dout == '0));
endmodule

bind fifo_rt fifo_rt_chk #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .rd_n(rd_n), .rt_n(rt_n),
  .dout(dout), .dout_oe(dout_oe), .empty_n(empty_n), .full_n(full_n),
  .half_n(half_n), .wptr(wptr), .rptr(rptr), .count(count)
);

// File: tb/tb_fifo_rt.sv
module tb_fifo_rt;
  localparam int DEPTH = 256;
  localparam int WIDTH = 9;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_n = 1'b1, rd_n = 1'b1, rt_n = 1'b1;
  logic [WIDTH-1:0] din = '0;
  logic [WIDTH-1:0] dout;
  logic dout_oe, empty_n, full_n, half_n;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  string tag = "R1";

  int q[$];
  int hist[$];
  int exp_dout = 0;
  bit exp_oe = 1'b0;

  fifo_rt #(.DEPTH(DEPTH), .WIDTH(WIDTH)) dut (
    .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .rd_n(rd_n), .rt_n(rt_n),
    .din(din), .dout(dout), .dout_oe(dout_oe), .empty_n(empty_n),
    .full_n(full_n), .half_n(half_n)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s (%s) at %0t: actual %0d expected %0d", req, tag, $time, act, exp);
    end
  endtask

  task automatic compare();
    check(empty_n == (q.size() != 0), "R4 empty flag", empty_n, q.size() != 0);
    check(full_n == (q.size() != DEPTH), "R3 full flag", full_n, q.size() != DEPTH);
    check(half_n == !(q.size() > DEPTH/2), "R6 half flag", half_n, !(q.size() > DEPTH/2));
    check(dout_oe == exp_oe, "R8 output enable", dout_oe, exp_oe);
    check(int'(dout) == exp_dout, "R2 read data", dout, exp_dout);
  endtask

  task automatic step(bit w, bit r, bit t, int d);
    bit acc_w, acc_r;
    wr_n = w; rd_n = r; rt_n = t; din = WIDTH'(d);
    @(posedge clk);
    if (!t) begin
      q = hist;
      exp_oe = 1'b0; exp_dout = 0;
    end else begin
      acc_w = !w && (q.size() < DEPTH);
      acc_r = !r && (q.size() > 0);
      exp_oe = acc_r;
      exp_dout = acc_r ? q[0] : 0;
      if (acc_r) void'(q.pop_front());
      if (acc_w) begin q.push_back(d & 9'h1FF); hist.push_back(d & 9'h1FF); end
    end
    @(negedge clk);
    compare();
  endtask

  task automatic do_reset();
    wr_n = 1'b1; rd_n = 1'b1; rt_n = 1'b1;
    rst_n = 1'b0;
    q.delete(); hist.delete(); exp_oe = 1'b0; exp_dout = 0;
    repeat (2) @(negedge clk);
    tag = "R1";
    check(empty_n == 1'b0, "R1 empty after reset", empty_n, 0);
    check(full_n == 1'b1, "R1 full after reset", full_n, 1);
    check(half_n == 1'b1, "R1 half after reset", half_n, 1);
    check(dout_oe == 1'b0, "R1 oe after reset", dout_oe, 0);
    rst_n = 1'b1;
    @(negedge clk);
    compare();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();

    tag = "R4";
    for (int i = 0; i < 3; i++) step(1, 0, 1, 0);

    tag = "R2";
    for (int i = 0; i < 10; i++) step(0, 1, 1, 9'h1A0 + i * 7);
    for (int i = 0; i < 4; i++) step(1, 0, 1, 0);
    for (int i = 0; i < 6; i++) begin step(0, 1, 1, 300 + i); step(1, 0, 1, 0); end
    for (int i = 0; i < 8; i++) step(1, 0, 1, 0);

    tag = "R3";
    for (int i = 0; i < DEPTH; i++) step(0, 1, 1, (i * 37 + 5) % 512);
    check(full_n == 1'b0, "R3 full after DEPTH writes", full_n, 0);
    for (int i = 0; i < 3; i++) step(0, 1, 1, 9'h055);
    tag = "R5";
    step(0, 0, 1, 9'h0AA);
    for (int i = 0; i < 5; i++) step(0, 0, 1, 9'h100 + i);

    tag = "R6";
    for (int i = 0; i < DEPTH/2 - 2; i++) step(1, 0, 1, 0);
    for (int i = 0; i < 4; i++) step(1, 0, 1, 0);
    tag = "R5";
    for (int i = 0; i < 4; i++) step(0, 0, 1, 9'h0C0 + i);
    tag = "R6";
    step(0, 1, 1, 9'h0F0);
    step(1, 0, 1, 0);
    step(1, 0, 1, 0);
    for (int i = 0; i < DEPTH; i++) step(1, 0, 1, 0);
    check(empty_n == 1'b0, "R4 empty after drain", empty_n, 0);
    tag = "R5";
    step(0, 0, 1, 9'h033);
    step(1, 0, 1, 0);

    do_reset();
    tag = "R7";
    for (int i = 0; i < 20; i++) step(0, 1, 1, 9'h1F0 - i * 3);
    for (int i = 0; i < 7; i++) step(1, 0, 1, 0);
    step(1, 1, 0, 0);
    check(half_n == 1'b1 && empty_n == 1'b1, "R7 flags after rewind", {half_n, empty_n}, 3);
    step(0, 0, 0, 9'h111);
    for (int i = 0; i < 25; i++) step(1, 0, 1, 0);
    step(0, 1, 1, 9'h077);
    step(1, 1, 0, 0);
    for (int i = 0; i < 23; i++) step(1, 0, 1, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule